// File: doc/BRIEF.md
# Frame Word Pixel Unpacker

This block sits between the frame-buffer fetch path and the pixel pipeline of a display controller. It accepts 32-bit words on a valid/ready handshake, keeps each word until every pixel packed in it has been sent, and emits one pixel per clock as 24-bit RGB (red in bits 23:16, green in 15:8, blue in 7:0). A 3-bit depth code picks the packing. Two ordering bits choose how pixels are laid out in the word. A swap bit exchanges red and blue. A 2-bit board-level format input chooses how 16-bit pixels are read.

For the four indexed depths the extracted index goes out on a lookup port to an external colour table. The table answers combinationally in the same cycle, and that answer becomes the output pixel. For direct-colour depths each channel is widened to 8 bits by shifting it left. The parameter `EXTENDED` selects the richer variant. That variant decodes 565 and 12-bit depths from the depth code itself and ignores the board format input. The block also reports, one cycle late, how many source bytes a line of a given pixel width occupies at the current depth. The depth and ordering inputs must be held steady while a word is in flight.

Top module: `pixel_unpacker`

## Requirements
- R1: After synchronous reset, `pix_valid_o` is 0, `word_ready_o` is 1 and `line_bytes_o` is 0.
- R2: Depth codes 0..7 give 32, 16, 8, 4, 2, 2, 2 and 1 pixels per word for codes 0,1,2,3,4,6,7,5 respectively. A held word yields exactly that many pixels on consecutive cycles. The first pixel appears one cycle after the word is accepted. `word_ready_o` is high only when no word is held or the last pixel of the held word is being produced, so back-to-back words stream without gaps.
- R3: Depth codes 0..3 mean 1, 2, 4 and 8 bits per pixel. With both ordering bits clear, pixel k of a word is read from bits [k*bpp +: bpp], so the first pixel comes from the LSBs. The index, zero-extended, is driven on `pal_idx_o`, and the colour returned on `pal_rgb_i` becomes the output unchanged, with no red/blue swap.
- R4: With `pix_be_i`=1 and `byte_be_i`=0 at 1, 2 or 4 bpp, bytes are still taken from byte 0 up, but within each byte the pixels are taken from the most significant end first. At 8 bpp and above the bit has no effect.
- R5: With `byte_be_i`=1, the four bytes of the word are reversed (byte 3 first) before extraction, and pixels inside a byte are taken LSB first. This holds whatever the value of `pix_be_i`, so byte reversal wins over pixel reversal.
- R6: Code 5 (32 bpp, one pixel per word) takes red from bits 7:0, green from 15:8 and blue from 23:16, and ignores bits 31:24. For every direct-colour format, `bgr_i`=1 swaps the red and blue output fields unless a requirement below forces the order.
- R7: In the non-extended variant, code 4 uses two 16-bit containers per word, the low half first. With `fmt_mux_i`=1 it is read as 5551: red [4:0], green [9:5], blue [14:10], each shifted left 3, bit 15 ignored. With `fmt_mux_i`=0 or 2 it is read as 565: red [4:0]<<3, green [10:5]<<2, blue [15:11]<<3, with `bgr_i` honoured. With `fmt_mux_i`=3 it is read as 565 with red and blue always swapped.
- R8: In the extended variant, `fmt_mux_i` has no effect. Code 4 is always 5551, code 6 is 565 and code 7 is 12-bit (red [3:0], green [7:4], blue [11:8], each shifted left 4, bits 15:12 ignored). All three use 16-bit containers and honour `bgr_i`.
- R9: In the non-extended variant, codes 6 and 7 still consume two pixels per word but every output pixel is zero.
- R10: `line_bytes_o` equals, one cycle after the inputs, `line_width_i` shifted right by 3, 2 or 1 for codes 0, 1, 2. It equals the width for code 3, the width shifted left 1 for codes 4, 6 and 7, and the width shifted left 2 for code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Depth code |
| byte_be_i | input | 1 | Reverse byte order within the word |
| pix_be_i | input | 1 | Reverse pixel order within each byte |
| bgr_i | input | 1 | Swap red and blue for direct colour |
| fmt_mux_i | input | 2 | Board-level 16-bit format select |
| word_valid_i | input | 1 | Source word valid |
| word_i | input | 32 | Source word |
| word_ready_o | output | 1 | Block can take a word this cycle |
| pal_idx_o | output | 8 | Colour table index for indexed depths |
| pal_rgb_i | input | 24 | Colour table answer for `pal_idx_o` |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Output pixel, red high |
| line_width_i | input | LW_W | Line width in pixels |
| line_bytes_o | output | LW_W+2 | Source bytes per line |

## Verification
The hardest situation to reach is a word handover under a continuously asserted valid. The last pixel of one word and the acceptance of the next must meet in the same cycle, with no bubble and no duplicated pixel. The stimulus holds valid high across pairs of words in every depth, ordering and format combination, and sends isolated words as well. A behavioural queue model predicts every pixel and is compared on each clock. Two instances, one of each variant, receive identical stimulus, so the format input can be shown to matter in one and be ignored in the other.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;
  localparam int OFF_W  = 5;

  typedef enum logic [2:0] {
    DEP_1   = 3'd0,
    DEP_2   = 3'd1,
    DEP_4   = 3'd2,
    DEP_8   = 3'd3,
    DEP_16  = 3'd4,
    DEP_32  = 3'd5,
    DEP_565 = 3'd6,
    DEP_12  = 3'd7
  } depth_e;

  // log2 of the container stride in bits
  function automatic logic [2:0] stride_lg(input logic [2:0] m);
    case (m)
      3'd0, 3'd1, 3'd2, 3'd3: stride_lg = m;
      3'd5:                   stride_lg = 3'd5;
      default:                stride_lg = 3'd4;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] last_pix(input logic [2:0] m);
    case (m)
      3'd0:    last_pix = 5'd31;
      3'd1:    last_pix = 5'd15;
      3'd2:    last_pix = 5'd7;
      3'd3:    last_pix = 5'd3;
      3'd5:    last_pix = 5'd0;
      default: last_pix = 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/pxu_pick.sv
module pxu_pick
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [2:0]        mode_i,
  input  logic              byte_be_i,
  input  logic              pix_be_i,
  output logic [WORD_W-1:0] raw_o
);
  logic [WORD_W-1:0] ordered;
  logic [OFF_W-1:0]  off;
  logic [2:0]        lg;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    ordered = byte_be_i ? {word_i[7:0], word_i[15:8], word_i[23:16], word_i[31:24]} : word_i;
    lg      = stride_lg(mode_i);
    off     = OFF_W'(cnt_i << lg);
    if (pix_be_i && !byte_be_i && lg < 3'd3)
      off[2:0] = 3'(4'd8 - (4'd1 << lg)) - off[2:0];
    shifted = ordered >> off;
    case (lg)
      3'd0:    raw_o = {31'd0, shifted[0]};
      3'd1:    raw_o = {30'd0, shifted[1:0]};
      3'd2:    raw_o = {28'd0, shifted[3:0]};
      3'd3:    raw_o = {24'd0, shifted[7:0]};
      3'd4:    raw_o = {16'd0, shifted[15:0]};
      default: raw_o = shifted;
    endcase
  end
endmodule

// File: rtl/pxu_expand.sv
module pxu_expand
  import pxu_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic [WORD_W-1:0] raw_i,
  input  logic [2:0]        mode_i,
  input  logic              bgr_i,
  input  logic [1:0]        fmt_mux_i,
  input  logic [23:0]       pal_rgb_i,
  output logic [23:0]       rgb_o
);
  logic [7:0] r, g, b;
  logic       swap, blank, indexed;

  always_comb begin
    r = '0; g = '0; b = '0;
    swap    = bgr_i;
    blank   = 1'b0;
    indexed = (mode_i <= 3'd3);
    case (mode_i)
      3'd5: begin
        r = raw_i[7:0]; g = raw_i[15:8]; b = raw_i[23:16];
      end
      3'd4: begin
        if (EXTENDED || fmt_mux_i == 2'd1) begin
          r = {raw_i[4:0], 3'b0}; g = {raw_i[9:5], 3'b0}; b = {raw_i[14:10], 3'b0};
        end else begin
          r = {raw_i[4:0], 3'b0}; g = {raw_i[10:5], 2'b0}; b = {raw_i[15:11], 3'b0};
          if (fmt_mux_i == 2'd3) swap = 1'b1;
        end
      end
      3'd6: begin
        r = {raw_i[4:0], 3'b0}; g = {raw_i[10:5], 2'b0}; b = {raw_i[15:11], 3'b0};
        blank = !EXTENDED;
      end
      3'd7: begin
        r = {raw_i[3:0], 4'b0}; g = {raw_i[7:4], 4'b0}; b = {raw_i[11:8], 4'b0};
        blank = !EXTENDED;
      end
      default: ;
    endcase
    if (indexed)    rgb_o = pal_rgb_i;
    else if (blank) rgb_o = '0;
    else if (swap)  rgb_o = {b, g, r};
    else            rgb_o = {r, g, b};
  end
endmodule

// File: rtl/pxu_linebytes.sv
module pxu_linebytes #(
  parameter int LW_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      mode_i,
  input  logic [LW_W-1:0] width_i,
  output logic [LW_W+1:0] bytes_o
);
  localparam int OUT_W = LW_W + 2;
  logic [OUT_W-1:0] nxt;

  always_comb begin
    case (mode_i)
      3'd0:    nxt = OUT_W'(width_i >> 3);
      3'd1:    nxt = OUT_W'(width_i >> 2);
      3'd2:    nxt = OUT_W'(width_i >> 1);
      3'd3:    nxt = OUT_W'(width_i);
      3'd5:    nxt = {width_i, 2'b00};
      default: nxt = {1'b0, width_i, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bytes_o <= '0;
    else     bytes_o <= nxt;
  end

  assert_line_wide_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd5) |=> (bytes_o == {$past(width_i), 2'b00}));
  assert_line_narrow_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0) |=> (bytes_o == OUT_W'($past(width_i) >> 3)));
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pxu_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int LW_W     = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         mode_i,
  input  logic               byte_be_i,
  input  logic               pix_be_i,
  input  logic               bgr_i,
  input  logic [1:0]         fmt_mux_i,
  input  logic               word_valid_i,
  input  logic [31:0]        word_i,
  output logic               word_ready_o,
  output logic [7:0]         pal_idx_o,
  input  logic [23:0]        pal_rgb_i,
  output logic               pix_valid_o,
  output logic [23:0]        pix_rgb_o,
  input  logic [LW_W-1:0]    line_width_i,
  output logic [LW_W+1:0]    line_bytes_o
);
  logic              full_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last;
  logic              take;
  logic [WORD_W-1:0] raw;
  logic [23:0]       rgb;

  assign last         = full_q && (cnt_q == last_pix(mode_i));
  assign word_ready_o = !full_q || last;
  assign take         = word_valid_i && word_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      word_q <= word_i;
      cnt_q  <= '0;
    end else if (last) begin
      full_q <= 1'b0;
    end else if (full_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  pxu_pick u_pick (
    .word_i    (word_q),
    .cnt_i     (cnt_q),
    .mode_i    (mode_i),
    .byte_be_i (byte_be_i),
    .pix_be_i  (pix_be_i),
    .raw_o     (raw)
  );

  assign pal_idx_o = raw[7:0];

  pxu_expand #(.EXTENDED(EXTENDED)) u_expand (
    .raw_i     (raw),
    .mode_i    (mode_i),
    .bgr_i     (bgr_i),
    .fmt_mux_i (fmt_mux_i),
    .pal_rgb_i (pal_rgb_i),
    .rgb_o     (rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid_o <= 1'b0;
      pix_rgb_o   <= '0;
    end else begin
      pix_valid_o <= full_q;
      pix_rgb_o   <= full_q ? rgb : '0;
    end
  end

  pxu_linebytes #(.LW_W(LW_W)) u_line (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .width_i (line_width_i),
    .bytes_o (line_bytes_o)
  );

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    full_q |=> pix_valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !full_q |=> !pix_valid_o);
  assert_hold_word_R2: assert property (@(posedge clk) disable iff (rst)
    (full_q && !last) |=> $stable(word_q));
  assert_index_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (full_q && mode_i <= 3'd3) |=> (pix_rgb_o == $past(pal_rgb_i)));
  assert_blank_depth_R9: assert property (@(posedge clk) disable iff (rst)
    (!EXTENDED && full_q && mode_i[2:1] == 2'b11 && $stable(mode_i)) |=> (pix_rgb_o == 24'd0));
endmodule

// File: tb/pixel_unpacker_tb_top.sv
module pixel_unpacker_tb_top;
  localparam int LW_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_i = '0;
  logic byte_be_i = 1'b0, pix_be_i = 1'b0, bgr_i = 1'b0;
  logic [1:0] fmt_mux_i = '0;
  logic word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [LW_W-1:0] line_width_i = '0;

  logic ready_n, ready_x, pv_n, pv_x;
  logic [7:0] idx_n, idx_x;
  logic [23:0] pal_n, pal_x, rgb_n, rgb_x;
  logic [LW_W+1:0] lb_n, lb_x;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  function automatic logic [23:0] pal_of(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  assign pal_n = pal_of(idx_n);
  assign pal_x = pal_of(idx_x);

  pixel_unpacker #(.EXTENDED(1'b0), .LW_W(LW_W)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .byte_be_i(byte_be_i), .pix_be_i(pix_be_i),
    .bgr_i(bgr_i), .fmt_mux_i(fmt_mux_i), .word_valid_i(word_valid_i), .word_i(word_i),
    .word_ready_o(ready_n), .pal_idx_o(idx_n), .pal_rgb_i(pal_n), .pix_valid_o(pv_n),
    .pix_rgb_o(rgb_n), .line_width_i(line_width_i), .line_bytes_o(lb_n));

  pixel_unpacker #(.EXTENDED(1'b1), .LW_W(LW_W)) dut_x_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .byte_be_i(byte_be_i), .pix_be_i(pix_be_i),
    .bgr_i(bgr_i), .fmt_mux_i(fmt_mux_i), .word_valid_i(word_valid_i), .word_i(word_i),
    .word_ready_o(ready_x), .pal_idx_o(idx_x), .pal_rgb_i(pal_x), .pix_valid_o(pv_x),
    .pix_rgb_o(rgb_x), .line_width_i(line_width_i), .line_bytes_o(lb_x));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bpp_of(input logic [2:0] m);
    if (m < 3'd4) return 1 << m;
    if (m == 3'd5) return 32;
    return 16;
  endfunction

  // model: raw field of pixel k
  function automatic logic [31:0] model_pick(input logic [31:0] w, input logic [2:0] m,
                                             input int k, input logic bbe, input logic pbe);
    logic [31:0] v;
    int bpp, ppb, bi, j;
    logic [7:0] by;
    v = bbe ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    bpp = bpp_of(m);
    if (bpp < 8) begin
      ppb = 8 / bpp;
      bi = k / ppb;
      j = k % ppb;
      if (pbe && !bbe) j = ppb - 1 - j;
      by = v[bi*8 +: 8];
      return 32'((by >> (j*bpp)) & ((1 << bpp) - 1));
    end
    if (bpp == 32) return v;
    return 32'((64'(v) >> (k*bpp)) & ((64'd1 << bpp) - 1));
  endfunction

  function automatic logic [23:0] model_col(input bit ext, input logic [2:0] m, input logic [1:0] mux,
                                            input logic bgr, input logic [31:0] p);
    logic [7:0] r, g, b;
    logic sw;
    sw = bgr;
    if (m <= 3'd3) return pal_of(p[7:0]);
    if (m == 3'd5) begin r = p[7:0]; g = p[15:8]; b = p[23:16]; end
    else if (m == 3'd7) begin
      if (!ext) return 24'd0;
      r = {p[3:0], 4'h0}; g = {p[7:4], 4'h0}; b = {p[11:8], 4'h0};
    end else if (m == 3'd4 && (ext || mux == 2'd1)) begin
      r = {p[4:0], 3'd0}; g = {p[9:5], 3'd0}; b = {p[14:10], 3'd0};
    end else begin
      if (m == 3'd6 && !ext) return 24'd0;
      r = {p[4:0], 3'd0}; g = {p[10:5], 2'd0}; b = {p[15:11], 3'd0};
      if (m == 3'd4 && mux == 2'd3) sw = 1'b1;
    end
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  function automatic string tag_of(input bit ext, input logic [2:0] m, input logic bbe, input logic pbe);
    if (bbe) return "R5";
    if (pbe && m < 3'd3) return "R4";
    if (m <= 3'd3) return "R3";
    if (m == 3'd5) return "R6";
    if (ext) return "R8";
    if (m == 3'd4) return "R7";
    return "R9";
  endfunction

  logic [23:0] q_n[$], q_x[$];
  string t_n[$], t_x[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid_i && ready_n) begin
        for (int k = 0; k < 32 / bpp_of(mode_i) * (mode_i == 3'd5 ? 1 : 1); k++) begin
          logic [31:0] p;
          p = model_pick(word_i, mode_i, k, byte_be_i, pix_be_i);
          q_n.push_back(model_col(1'b0, mode_i, fmt_mux_i, bgr_i, p));
          q_x.push_back(model_col(1'b1, mode_i, fmt_mux_i, bgr_i, p));
          t_n.push_back(tag_of(1'b0, mode_i, byte_be_i, pix_be_i));
          t_x.push_back(tag_of(1'b1, mode_i, byte_be_i, pix_be_i));
        end
      end
      if (ready_n !== ready_x) check("R2 ready", {31'd0, ready_x}, {31'd0, ready_n});
      if (pv_n) begin
        if (q_n.size() == 0) check("R2 extra pixel", 32'd1, 32'd0);
        else begin check(t_n.pop_front(), {8'd0, rgb_n}, {8'd0, q_n.pop_front()}); end
      end
      if (pv_x) begin
        if (q_x.size() == 0) check("R2 extra pixel x", 32'd1, 32'd0);
        else begin check(t_x.pop_front(), {8'd0, rgb_x}, {8'd0, q_x.pop_front()}); end
      end
    end
  end

  task automatic send(input logic [31:0] w, input bit keep);
    word_valid_i = 1'b1;
    word_i = w;
    do @(negedge clk); while (!ready_n);
    @(posedge clk); #1;
    if (!keep) word_valid_i = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (q_n.size() != 0 || q_x.size() != 0 || !ready_n);
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    #(10 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    int exp_lb;
    int widths[3];
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pix_valid", {31'd0, pv_n}, 32'd0);
    check("R1 ready", {31'd0, ready_n}, 32'd1);
    check("R1 line_bytes", 32'(lb_n), 32'd0);
    @(posedge clk); #1;

    seed = 32'hA5C3_1E96;
    for (int m = 0; m < 8; m++)
      for (int ord = 0; ord < 4; ord++)
        for (int bg = 0; bg < 2; bg++)
          for (int mx = 0; mx < 4; mx++) begin
            if (m != 4 && m != 6 && mx != 0) continue;
            mode_i = 3'(m); byte_be_i = ord[1]; pix_be_i = ord[0];
            bgr_i = bg[0]; fmt_mux_i = 2'(mx);
            seed = seed * 32'd1664525 + 32'd1013904223;
            send(seed, 1'b1);                        // R2 back-to-back handover
            send(seed ^ 32'h8001_7FFE, 1'b0);
            repeat (ord) @(posedge clk);
            #1;
            send(~seed, 1'b0);                       // isolated word
            drain();
          end

    // R2 all predicted pixels were delivered
    check("R2 queue empty", 32'(q_n.size() + q_x.size()), 32'd0);

    // R10 bytes per line
    widths[0] = 640; widths[1] = 7; widths[2] = 4095;
    for (int m = 0; m < 8; m++)
      for (int wi = 0; wi < 3; wi++) begin
        mode_i = 3'(m);
        line_width_i = LW_W'(widths[wi]);
        @(negedge clk); @(negedge clk);
        case (m)
          0: exp_lb = widths[wi] >> 3;
          1: exp_lb = widths[wi] >> 2;
          2: exp_lb = widths[wi] >> 1;
          3: exp_lb = widths[wi];
          5: exp_lb = widths[wi] * 4;
          default: exp_lb = widths[wi] * 2;
        endcase
        check("R10 line bytes", 32'(lb_n), 32'(exp_lb));
        check("R10 line bytes x", 32'(lb_x), 32'(exp_lb));
        @(posedge clk); #1;
      end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule